// File: doc/BRIEF.md
# Field Memory Serial Address Pointer

This block produces the serial (line, word) address for one port of a memory organised as lines of words. An address register keeps a preset line number loaded by address-set cycles. An address counter supplies the current line (X) and word within the line (Y). The counter steps once per serial access strobe. At the end of a line it moves to the first word of the next line, and after the last line it returns to line 0.

A reset cycle is a single clock with the port's reset command high. A 2-bit mode code, sampled in that cycle, chooses one of four pointer moves:

- restart at (0,0) while keeping the preset;
- advance to the next line;
- jump to the preset line;
- return to the start of the current line. This one is allowed on a read port only.

The port takes no data access during a reset or address-set cycle. After such a cycle, access stays locked out for a fixed number of clocks.

A read port and a write port each use their own instance, so each port resets without disturbing the other. Commands that are malformed or not allowed on the port leave the pointer untouched and raise a one-cycle error flag.

Top module: `fmem_addr_ptr`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `addr_x`=0, `addr_y`=0, `acc_en`=0 and `mode_err`=0. The preset line is also cleared to 0.
- R2: An address-set cycle (`addr_set`=1, `ptr_rst`=0, `set_line` < LINES) stores `set_line` as the preset. It also moves the pointer to (`set_line`, 0).
- R3: Each `acc` strobe taken while `acc_en`=1 and no command is present does the following:
  - It advances Y by one.
  - When Y = WPL-1, Y becomes 0 and X advances.
  - When X = LINES-1, X advances to 0.
- R4: Mode code 0 (restart) moves the pointer to (0,0) and leaves the preset unchanged.
- R5: Mode code 1 (next line) sets X to X+1, wrapping to 0 after LINES-1, and sets Y to 0.
- R6: Mode code 2 (jump) sets the pointer to (preset, 0).
- R7: Mode code 3 (line start) on a read port (IS_READ=1) sets Y to 0 and keeps X.
- R8: On a write port (IS_READ=0), mode code 3 is rejected. The pointer is unchanged and `mode_err` is 1 for one cycle.
- R9: `ptr_rst` and `addr_set` high together are rejected. The pointer and the preset are unchanged and `mode_err` is 1 for one cycle.
- R10: After any command cycle, `acc_en` is 0 for that cycle's result and for EN_DELAY further clocks. It rises on the next clock. Strobes taken while it is 0 have no effect.
- R11: Two instances, one per port, are fully independent. A port keeps stepping while the other port is in reset cycles.
- R12: An address-set cycle with `set_line` >= LINES is rejected. The pointer and the preset are unchanged and `mode_err` is 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_rst | input | 1 | Pointer reset command for this port |
| ptr_mode | input | 2 | Reset kind: 0 restart, 1 next line, 2 jump, 3 line start |
| addr_set | input | 1 | Address-set cycle |
| set_line | input | XW | Line number to preset |
| acc | input | 1 | Serial access strobe |
| addr_x | output | XW | Current line |
| addr_y | output | YW | Current word in line |
| acc_en | output | 1 | Access allowed |
| mode_err | output | 1 | Previous command was rejected |

## Verification
The assertions check several properties on every clock:
- Y and X stay inside their ranges.
- A command cycle always closes `acc_en`.
- A locked-out strobe never moves the pointer.
- Every rejected command holds the pointer and raises the error flag.
- A restart keeps the preset, and a jump lands on it.

Only the bench scenarios can show the exact length of the lockout window and the wrap order across line and field ends. They also show that a jump after an intervening restart still reaches the line set earlier, and that one port runs on while the other resets.

// File: rtl/fmem_ptr_pkg.sv
package fmem_ptr_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_SET, OP_ORIG, OP_LINC, OP_JUMP, OP_HOLD
  } ptr_op_e;

  localparam logic [1:0] MD_ORIG = 2'd0;
  localparam logic [1:0] MD_LINC = 2'd1;
  localparam logic [1:0] MD_JUMP = 2'd2;
  localparam logic [1:0] MD_HOLD = 2'd3;
endpackage

// File: rtl/fmem_ptr_decode.sv
module fmem_ptr_decode
  import fmem_ptr_pkg::*;
#(
  parameter int LINES   = 8,
  parameter bit IS_READ = 1'b1,
  parameter int XW      = 3
) (
  input  logic          ptr_rst,
  input  logic [1:0]    mode,
  input  logic          set_en,
  input  logic [XW-1:0] set_x,
  output ptr_op_e       op,
  output logic          bad
);
  always_comb begin
    op  = OP_NONE;
    bad = 1'b0;
    if (ptr_rst && set_en) begin
      bad = 1'b1;
    end else if (set_en) begin
      if (int'(set_x) >= LINES) bad = 1'b1;
      else                      op  = OP_SET;
    end else if (ptr_rst) begin
      case (mode)
        MD_ORIG: op = OP_ORIG;
        MD_LINC: op = OP_LINC;
        MD_JUMP: op = OP_JUMP;
        default: begin
          if (IS_READ) op  = OP_HOLD;
          else         bad = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/fmem_ptr_lockout.sv
module fmem_ptr_lockout #(
  parameter int EN_DELAY = 4,
  localparam int DW = (EN_DELAY < 1) ? 1 : $clog2(EN_DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic acc_en
);
  logic [DW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= DW'(EN_DELAY);
      acc_en <= 1'b0;
    end else if (cmd) begin
      wait_q <= DW'(EN_DELAY);
      acc_en <= 1'b0;
    end else begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      acc_en <= (wait_q == '0);
    end
  end

  // R10: a command cycle always closes access
  a_r10_lock_on_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd |=> !acc_en);
  // R10: access only reopens after a quiet cycle
  a_r10_open_after_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_en) |-> !$past(cmd));
endmodule

// File: rtl/fmem_ptr_counter.sv
module fmem_ptr_counter
  import fmem_ptr_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WPL   = 5,
  parameter int XW    = 3,
  parameter int YW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  ptr_op_e       op,
  input  logic [XW-1:0] set_x,
  input  logic          step,
  output logic [XW-1:0] x_q,
  output logic [YW-1:0] y_q
);
  localparam logic [XW-1:0] LAST_X = XW'(LINES - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(WPL - 1);

  logic [XW-1:0] preset_q;
  logic [XW-1:0] x_inc;

  assign x_inc = (x_q == LAST_X) ? '0 : x_q + XW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q      <= '0;
      y_q      <= '0;
      preset_q <= '0;
    end else begin
      case (op)
        OP_SET: begin
          preset_q <= set_x;
          x_q      <= set_x;
          y_q      <= '0;
        end
        OP_ORIG: begin
          x_q <= '0;
          y_q <= '0;
        end
        OP_LINC: begin
          x_q <= x_inc;
          y_q <= '0;
        end
        OP_JUMP: begin
          x_q <= preset_q;
          y_q <= '0;
        end
        OP_HOLD: y_q <= '0;
        default: begin
          if (step) begin
            if (y_q == LAST_Y) begin
              y_q <= '0;
              x_q <= x_inc;
            end else begin
              y_q <= y_q + YW'(1);
            end
          end
        end
      endcase
    end
  end

  // R3: pointer stays inside the field
  a_r3_y_range: assert property (@(posedge clk) disable iff (rst)
    int'(y_q) < WPL);
  a_r3_x_range: assert property (@(posedge clk) disable iff (rst)
    int'(x_q) < LINES);
  // R4: restart keeps the preset line
  a_r4_orig_keeps_preset: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ORIG) |=> $stable(preset_q) && x_q == '0 && y_q == '0);
  // R6: jump lands on the preset line
  a_r6_jump_to_preset: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JUMP) |=> x_q == $past(preset_q) && y_q == '0);
endmodule

// File: rtl/fmem_addr_ptr.sv
module fmem_addr_ptr
  import fmem_ptr_pkg::*;
#(
  parameter int LINES    = 240,
  parameter int WPL      = 928,
  parameter int EN_DELAY = 4,
  parameter bit IS_READ  = 1'b1,
  localparam int XW = (LINES < 2) ? 1 : $clog2(LINES),
  localparam int YW = (WPL < 2) ? 1 : $clog2(WPL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_rst,
  input  logic [1:0]    ptr_mode,
  input  logic          addr_set,
  input  logic [XW-1:0] set_line,
  input  logic          acc,
  output logic [XW-1:0] addr_x,
  output logic [YW-1:0] addr_y,
  output logic          acc_en,
  output logic          mode_err
);
  ptr_op_e op;
  logic    bad;
  logic    cmd;
  logic    step;

  assign cmd  = ptr_rst | addr_set;
  assign step = acc & acc_en & ~cmd;

  fmem_ptr_decode #(.LINES(LINES), .IS_READ(IS_READ), .XW(XW)) u_dec (
    .ptr_rst(ptr_rst), .mode(ptr_mode), .set_en(addr_set),
    .set_x(set_line), .op(op), .bad(bad)
  );

  fmem_ptr_counter #(.LINES(LINES), .WPL(WPL), .XW(XW), .YW(YW)) u_cnt (
    .clk(clk), .rst(rst), .op(op), .set_x(set_line), .step(step),
    .x_q(addr_x), .y_q(addr_y)
  );

  fmem_ptr_lockout #(.EN_DELAY(EN_DELAY)) u_lock (
    .clk(clk), .rst(rst), .cmd(cmd), .acc_en(acc_en)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_err <= 1'b0;
    else     mode_err <= bad;
  end

  // R10: a strobe while locked never moves the pointer
  a_r10_locked_no_step: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !cmd) |=> $stable(addr_x) && $stable(addr_y));
  // R9: reset and set together are rejected
  a_r9_conflict_rejected: assert property (@(posedge clk) disable iff (rst)
    (ptr_rst && addr_set) |=> mode_err && $stable(addr_x) && $stable(addr_y));
  // R8: line start on a write port is rejected
  a_r8_write_hold_rejected: assert property (@(posedge clk) disable iff (rst)
    (!IS_READ && ptr_rst && !addr_set && ptr_mode == MD_HOLD)
      |=> mode_err && $stable(addr_x) && $stable(addr_y));
  // R5: next line always starts at word 0
  a_r5_linc_word0: assert property (@(posedge clk) disable iff (rst)
    (ptr_rst && !addr_set && ptr_mode == MD_LINC) |=> addr_y == '0 && !mode_err);
endmodule

// File: tb/fmem_addr_ptr_bench.sv
module fmem_addr_ptr_bench;
  localparam int LINES = 5;
  localparam int WPL   = 3;
  localparam int DLY   = 2;
  localparam int NV    = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       rd_rst = 0, rd_set = 0, rd_acc = 0;
  logic [1:0] rd_md = 0;
  logic [2:0] rd_sx = 0;
  logic [2:0] rd_x;
  logic [1:0] rd_y;
  logic       rd_en, rd_err;

  logic       wr_rst = 0, wr_set = 0, wr_acc = 0;
  logic [1:0] wr_md = 0;
  logic [2:0] wr_sx = 0;
  logic [2:0] wr_x;
  logic [1:0] wr_y;
  logic       wr_en, wr_err;

  int checks = 0;
  int errors = 0;

  fmem_addr_ptr #(.LINES(LINES), .WPL(WPL), .EN_DELAY(DLY), .IS_READ(1'b1)) u_fmem_addr_ptr (
    .clk(clk), .rst(rst), .ptr_rst(rd_rst), .ptr_mode(rd_md), .addr_set(rd_set),
    .set_line(rd_sx), .acc(rd_acc), .addr_x(rd_x), .addr_y(rd_y),
    .acc_en(rd_en), .mode_err(rd_err)
  );

  fmem_addr_ptr #(.LINES(LINES), .WPL(WPL), .EN_DELAY(DLY), .IS_READ(1'b0)) u_fmem_addr_ptr_wr (
    .clk(clk), .rst(rst), .ptr_rst(wr_rst), .ptr_mode(wr_md), .addr_set(wr_set),
    .set_line(wr_sx), .acc(wr_acc), .addr_x(wr_x), .addr_y(wr_y),
    .acc_en(wr_en), .mode_err(wr_err)
  );

  // inputs {rst, mode[1:0], set, set_x[2:0], acc} then expected {x[2:0], y[1:0], en, err}
  function automatic logic [14:0] v(int rs, int md, int st, int sx, int ac,
                                    int ex, int ey, int en, int er);
    return {rs[0], md[1:0], st[0], sx[2:0], ac[0], ex[2:0], ey[1:0], en[0], er[0]};
  endfunction

  localparam logic [14:0] VEC [NV] = '{
    v(0,0,0,0,1, 0,0,0,0), v(0,0,0,0,1, 0,0,0,0), v(0,0,0,0,1, 0,0,1,0),
    v(0,0,0,0,1, 0,1,1,0), v(0,0,0,0,1, 0,2,1,0), v(0,0,0,0,1, 1,0,1,0),
    v(0,0,1,3,0, 3,0,0,0), v(0,0,0,0,1, 3,0,0,0), v(0,0,0,0,1, 3,0,0,0),
    v(0,0,0,0,1, 3,0,1,0), v(0,0,0,0,1, 3,1,1,0), v(0,0,0,0,1, 3,2,1,0),
    v(0,0,0,0,1, 4,0,1,0), v(0,0,0,0,1, 4,1,1,0), v(0,0,0,0,1, 4,2,1,0),
    v(0,0,0,0,1, 0,0,1,0), v(1,1,0,0,0, 1,0,0,0), v(0,0,0,0,0, 1,0,0,0),
    v(0,0,0,0,0, 1,0,0,0), v(0,0,0,0,0, 1,0,1,0), v(0,0,0,0,1, 1,1,1,0),
    v(1,3,0,0,0, 1,0,0,0), v(0,0,0,0,0, 1,0,0,0), v(0,0,0,0,0, 1,0,0,0),
    v(0,0,0,0,0, 1,0,1,0), v(0,0,0,0,1, 1,1,1,0), v(1,0,0,0,0, 0,0,0,0),
    v(0,0,0,0,0, 0,0,0,0), v(0,0,0,0,0, 0,0,0,0), v(0,0,0,0,0, 0,0,1,0),
    v(1,2,0,0,0, 3,0,0,0), v(1,0,1,2,0, 3,0,0,1), v(0,0,0,0,0, 3,0,0,0),
    v(0,0,1,6,0, 3,0,0,1), v(1,1,0,0,0, 4,0,0,0), v(1,1,0,0,0, 0,0,0,0)
  };

  function automatic string row_req(int i);
    if (i == 6)  return "R2";
    if (i == 16 || i >= 34) return "R5";
    if (i == 21) return "R7";
    if (i == 26) return "R4";
    if (i == 30) return "R6";
    if (i == 31) return "R9";
    if (i == 33) return "R12";
    if (i <= 2 || (i >= 7 && i <= 9) || (i >= 17 && i <= 19) ||
        (i >= 22 && i <= 24) || (i >= 27 && i <= 29) || i == 32) return "R10";
    return "R3";
  endfunction

  task automatic chk(string req, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual x=%0d y=%0d en=%0d err=%0d expected x=%0d y=%0d en=%0d err=%0d",
               req, got[6:4], got[3:2], got[1], got[0], exp[6:4], exp[3:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {rd_x, rd_y, rd_en, rd_err}, 7'd0);
    chk("R1", {wr_x, wr_y, wr_en, wr_err}, 7'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {rd_rst, rd_md, rd_set, rd_sx, rd_acc} = VEC[i][14:7];
      @(negedge clk);
      chk(row_req(i), {rd_x, rd_y, rd_en, rd_err}, VEC[i][6:0]);
    end
    // R11: write port steps while the read port is in a reset cycle
    {rd_rst, rd_md, rd_set, rd_acc} = {1'b1, 2'd0, 1'b0, 1'b0};
    wr_acc = 1'b1;
    @(negedge clk);
    chk("R11", {wr_x, wr_y, wr_en, wr_err}, {3'd0, 2'd1, 1'b1, 1'b0});
    chk("R11", {rd_x, rd_y, rd_en, rd_err}, {3'd0, 2'd0, 1'b0, 1'b0});
    // R8: line start code rejected on the write port
    rd_rst = 1'b0;
    wr_acc = 1'b0;
    wr_rst = 1'b1;
    wr_md  = 2'd3;
    @(negedge clk);
    chk("R8", {wr_x, wr_y, wr_en, wr_err}, {3'd0, 2'd1, 1'b0, 1'b1});
    wr_rst = 1'b0;
    wr_md  = 2'd0;
    @(negedge clk);
    chk("R8", {wr_x, wr_y, wr_en, wr_err}, {3'd0, 2'd1, 1'b0, 1'b0});
    // R1: reset in mid-run clears both ports
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {rd_x, rd_y, rd_en, rd_err}, 7'd0);
    chk("R1", {wr_x, wr_y, wr_en, wr_err}, 7'd0);
    rst = 1'b0;
    // R1: preset cleared, so a jump after reset lands on line 0
    rd_rst = 1'b1;
    rd_md  = 2'd2;
    @(negedge clk);
    chk("R1", {rd_x, rd_y, rd_en, rd_err}, 7'd0);
    rd_rst = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule